// File: doc/BRIEF.md
# Three-Function Down-Counting Timer

This block is a down-counter of parameterised width (16 bits by default) with two companion registers, a reload/capture register A and a reload/capture register B, and two pins, A and B. A three-bit function code in the control register picks what the counter does. It can generate a PWM waveform on its own, reloading alternately from register A and register B and optionally toggling pin A on each reload. It can count edges arriving on pin A. It can also free-run and latch its count into register A or register B when the selected edge appears on pin A or on pin B.

Software reaches four registers through a single-cycle write port and a combinational read port. Two interrupt outputs follow the pending flags, each gated by its own enable bit. Pin inputs pass through a two-stage synchronizer and an edge detector before any logic uses them. Prescaling and bus protocol belong to the surrounding logic. The register port is plain control access, so it has no valid/ready handshake and never applies back-pressure. A write is taken on every clock edge where the write strobe is high.

Top module: `tri_mode_timer`

## Requirements
- R1: With the counter running in a PWM code, a tick at count zero reloads the counter. The first reload after start loads register A, and later reloads alternate B, A, B and so on. The time between reloads is therefore (A+1) clocks, then (B+1) clocks, and the pattern repeats.
- R2: Code 101 toggles `txa_out` on every PWM reload, starting from 0 after reset. Code 100 leaves `txa_out` unchanged.
- R3: In PWM, a reload from register A sets the A pending flag and a reload from register B sets the B pending flag.
- R4: Control bit 0 is the run bit in the PWM and event codes. While it is 0, the counter holds its value and ignores clock ticks and pin edges.
- R5: Event code 000 decrements on each rising edge of `txa_in` and code 001 on each falling edge, provided the run bit is 1.
- R6: In event mode, a counted edge at count zero reloads register A and sets the A pending flag. A rising edge on `txb_in` sets the B pending flag.
- R7: In any capture code (middle mode bit = 1), the counter decrements every clock. A tick at zero wraps it to all ones and sets control bit 0, which then serves as the underflow flag.
- R8: The capture code selects the edge on each pin. The low mode bit picks the pin A edge (0 = rising, 1 = falling) and the high mode bit picks the pin B edge (0 = rising, 1 = falling). A selected edge on pin A copies the count into register A and sets the A pending flag. A selected edge on pin B does the same with register B and the B pending flag.
- R9: Pin edges pass through two synchronizing flops and an edge register. When a pin changes just after the clock edge at which the counter was written with V, register A receives V-2.
- R10: `irq_b` is the B pending flag AND the B enable. `irq_a` is the A enable AND either the A pending flag or, in capture codes, control bit 0.
- R11: Writing 0 clears a pending flag, and writing 1 leaves it as it was. When hardware sets a flag (or control bit 0 in capture) in the same cycle that software clears it, the set wins.
- R12: After reset, every register, `txa_out` and both interrupts are 0.
- R13: The register addresses are 0 = counter, 1 = register A, 2 = register B, 3 = control. The control bits are: bit 0 run/underflow, bit 1 A pending, bit 2 A enable, bit 3 B pending, bit 4 B enable, bits 7:5 mode code. Reads return the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data (control uses bits 7:0) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| txa_in | input | 1 | Pin A input (event and capture codes) |
| txb_in | input | 1 | Pin B input |
| txa_out | output | 1 | PWM waveform |
| irq_a | output | 1 | Interrupt A |
| irq_b | output | 1 | Interrupt B |

## Verification
The assertions assume that pins are asynchronous but stay at each level for at least three clocks. This guarantees that every edge produces exactly one single-cycle detect pulse. They also assume that software changes the function code only through full control writes. The stimulus holds every pin level for four or more clocks, and it rewrites the control register whenever it changes the code. It also clears any flags that a setup edge raised before it measures anything. The set-versus-clear race is hit on purpose by timing a control write to land on the cycle the counter wraps.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  typedef enum logic [1:0] {
    FN_EVENT = 2'd0,
    FN_PWM   = 2'd1,
    FN_CAPT  = 2'd2
  } tmt_fn_e;

  localparam int CTL_W  = 8;
  localparam int B_RUN  = 0;
  localparam int B_PA   = 1;
  localparam int B_EA   = 2;
  localparam int B_PB   = 3;
  localparam int B_EB   = 4;
  localparam int B_MODE = 5;

  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_RA  = 2'd1;
  localparam logic [1:0] A_RB  = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  // mode code m = {hi, mid, lo}; mid set = capture, hi set alone = pwm
  function automatic tmt_fn_e mode_fn(input logic [2:0] m);
    if (m[1])      return FN_CAPT;
    else if (m[2]) return FN_PWM;
    else           return FN_EVENT;
  endfunction
endpackage

// File: rtl/tmt_edge_sync.sv
module tmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R9
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  // R9
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] wr_byte,
  input  logic             set_a,
  input  logic             set_b,
  input  logic             set_c0,
  output logic [2:0]       mode,
  output tmt_fn_e          fn,
  output logic             run,
  output logic [CTL_W-1:0] ctl_q,
  output logic             irq_a,
  output logic             irq_b
);
  logic [2:0] mode_q;
  logic       c0_q, pa_q, ea_q, pb_q, eb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      c0_q   <= 1'b0;
      pa_q   <= 1'b0;
      ea_q   <= 1'b0;
      pb_q   <= 1'b0;
      eb_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        mode_q <= wr_byte[B_MODE +: 3];
        ea_q   <= wr_byte[B_EA];
        eb_q   <= wr_byte[B_EB];
      end
      c0_q <= (ctl_wr ? wr_byte[B_RUN] : c0_q) | set_c0;
      pa_q <= (ctl_wr ? (pa_q & wr_byte[B_PA]) : pa_q) | set_a;
      pb_q <= (ctl_wr ? (pb_q & wr_byte[B_PB]) : pb_q) | set_b;
    end
  end

  assign mode = mode_q;
  assign fn   = mode_fn(mode_q);
  assign run  = c0_q;

  always_comb begin
    ctl_q              = '0;
    ctl_q[B_RUN]       = c0_q;
    ctl_q[B_PA]        = pa_q;
    ctl_q[B_EA]        = ea_q;
    ctl_q[B_PB]        = pb_q;
    ctl_q[B_EB]        = eb_q;
    ctl_q[B_MODE +: 3] = mode_q;
  end

  assign irq_a = ea_q & (pa_q | ((fn == FN_CAPT) & c0_q));
  assign irq_b = eb_q & pb_q;

  // R11
  pend_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_q && !(ctl_wr && !wr_byte[B_PA])) |=> pa_q);
  // R11
  set_b_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_b |=> pb_q);
  // R11
  set_c0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_c0 |=> c0_q);
endmodule

// File: rtl/tmt_core.sv
module tmt_core
  import tmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmt_fn_e          fn,
  input  logic [2:0]       mode,
  input  logic             run,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rise,
  input  logic [1:0]       fall,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ra_q,
  output logic [CNT_W-1:0] rb_q,
  output logic             txa_out,
  output logic             set_a,
  output logic             set_b,
  output logic             set_c0
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic is_pwm, is_evt, is_capt;
  logic cnt_wr, ra_wr, rb_wr;
  logic a_evt_edge, capt_a, capt_b;
  logic tick, uf, use_rb_q, txa_q;
  logic reload_a, reload_b;

  assign is_pwm  = (fn == FN_PWM);
  assign is_evt  = (fn == FN_EVENT);
  assign is_capt = (fn == FN_CAPT);

  assign cnt_wr = wr_en && (wr_addr == A_CNT);
  assign ra_wr  = wr_en && (wr_addr == A_RA);
  assign rb_wr  = wr_en && (wr_addr == A_RB);

  assign a_evt_edge = mode[0] ? fall[0] : rise[0];
  assign capt_a     = is_capt & (mode[0] ? fall[0] : rise[0]);
  assign capt_b     = is_capt & (mode[2] ? fall[1] : rise[1]);

  assign tick = is_capt | (is_pwm & run) | (is_evt & run & a_evt_edge);
  assign uf   = tick & (cnt_q == '0) & ~cnt_wr;

  assign reload_a = is_pwm & uf & ~use_rb_q;
  assign reload_b = is_pwm & uf &  use_rb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= wr_data;
    end else if (uf) begin
      unique case (fn)
        FN_PWM:   cnt_q <= use_rb_q ? rb_q : ra_q;
        FN_EVENT: cnt_q <= ra_q;
        default:  cnt_q <= ALL_ONES;
      endcase
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               use_rb_q <= 1'b0;
    else if (!(is_pwm & run)) use_rb_q <= 1'b0;
    else if (uf)              use_rb_q <= ~use_rb_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  txa_q <= 1'b0;
    else if (is_pwm & uf & mode[0]) txa_q <= ~txa_q;
  end
  assign txa_out = txa_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ra_q <= '0;
    else if (ra_wr)  ra_q <= wr_data;
    else if (capt_a) ra_q <= cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rb_q <= '0;
    else if (rb_wr)  rb_q <= wr_data;
    else if (capt_b) rb_q <= cnt_q;
  end

  always_comb begin
    unique case (fn)
      FN_PWM: begin
        set_a = reload_a;
        set_b = reload_b;
      end
      FN_EVENT: begin
        set_a = uf;
        set_b = rise[1];
      end
      default: begin
        set_a = capt_a;
        set_b = capt_b;
      end
    endcase
  end
  assign set_c0 = is_capt & uf;

  // R7
  capt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_capt && cnt_q == '0 && !cnt_wr) |=> (cnt_q == ALL_ONES));
  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !is_capt && !cnt_wr) |=> $stable(cnt_q));
  // R2
  notoggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(is_pwm && mode[0])) |=> $stable(txa_out));
endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
  import tmt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             txa_in,
  input  logic             txb_in,
  output logic             txa_out,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pin_v, rise_v, fall_v;
  logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
  logic [CTL_W-1:0] ctl_q;
  logic [2:0]       mode;
  tmt_fn_e          fn;
  logic             run, set_a, set_b, set_c0, ctl_wr;

  assign pin_v  = {txb_in, txa_in};
  assign ctl_wr = wr_en && (wr_addr == A_CTL);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    tmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_v[p]),
      .rise (rise_v[p]),
      .fall (fall_v[p])
    );
  end

  tmt_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (ctl_wr),
    .wr_byte(wr_data[CTL_W-1:0]),
    .set_a  (set_a),
    .set_b  (set_b),
    .set_c0 (set_c0),
    .mode   (mode),
    .fn     (fn),
    .run    (run),
    .ctl_q  (ctl_q),
    .irq_a  (irq_a),
    .irq_b  (irq_b)
  );

  tmt_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .fn     (fn),
    .mode   (mode),
    .run    (run),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rise   (rise_v),
    .fall   (fall_v),
    .cnt_q  (cnt_q),
    .ra_q   (ra_q),
    .rb_q   (rb_q),
    .txa_out(txa_out),
    .set_a  (set_a),
    .set_b  (set_b),
    .set_c0 (set_c0)
  );

  always_comb begin
    unique case (rd_addr)
      A_CNT:   rd_data = cnt_q;
      A_RA:    rd_data = ra_q;
      A_RB:    rd_data = rb_q;
      default: rd_data = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
    endcase
  end
endmodule

// File: tb/tri_mode_timer_bench.sv
module tri_mode_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        txa_in, txb_in, txa_out, irq_a, irq_b;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  tri_mode_timer u_tri_mode_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .txa_in(txa_in), .txb_in(txb_in), .txa_out(txa_out),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // capture table: {mode[2:0], rising, exp_pend_a, exp_pend_b}
  localparam logic [5:0] CAPT_VEC [8] = '{
    {3'b010, 1'b1, 1'b1, 1'b1}, {3'b010, 1'b0, 1'b0, 1'b0},
    {3'b110, 1'b1, 1'b1, 1'b0}, {3'b110, 1'b0, 1'b0, 1'b1},
    {3'b011, 1'b1, 1'b0, 1'b1}, {3'b011, 1'b0, 1'b1, 1'b0},
    {3'b111, 1'b1, 1'b0, 1'b0}, {3'b111, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    txa_in = 1'b1; idle(4);
    txa_in = 1'b0; idle(4);
  endtask

  task automatic wait_toggle(output int n);
    logic prev;
    prev = txa_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (txa_out == prev && n < 1000);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000ns;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int v, n;
    bit changed;
    logic prev_o;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; txa_in = 1'b0; txb_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R12 reg zero", v, 0);
    end
    chk("R12 irq/txa", {irq_a, irq_b, txa_out}, 0);

    // R13 register map
    wr(2'd1, 16'h1234); wr(2'd2, 16'hBEEF);
    rd(2'd1, v); chk("R13 reg A", v, 16'h1234);
    rd(2'd2, v); chk("R13 reg B", v, 16'hBEEF);

    // PWM with toggle: A=3, B=5
    wr(2'd1, 16'd3); wr(2'd2, 16'd5); wr(2'd0, 16'd2);
    wr(2'd3, 16'hA1);
    wait_toggle(n);
    chk("R2 first toggle level", txa_out, 1);
    rd(2'd3, v); chk("R3 pend after A reload", v & 8'h0A, 8'h02);
    wait_toggle(n); chk("R1 interval A+1", n, 4);
    rd(2'd3, v); chk("R3 pend B after B reload", (v >> 3) & 1, 1);
    wait_toggle(n); chk("R1 interval B+1", n, 6);

    // PWM without toggle
    wr(2'd0, 16'd2); wr(2'd3, 16'h80); wr(2'd3, 16'h81);
    prev_o = txa_out; changed = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (txa_out != prev_o) changed = 1;
    end
    chk("R2 no toggle in 100", changed, 0);
    rd(2'd3, v); chk("R3 pend A in 100", (v >> 1) & 1, 1);

    // PWM stopped
    wr(2'd3, 16'h80); wr(2'd0, 16'd100); idle(10);
    rd(2'd0, v); chk("R4 pwm stopped holds", v, 100);

    // event counter
    wr(2'd1, 16'd20); wr(2'd0, 16'd10); wr(2'd3, 16'h01);
    pulse_a(); pulse_a(); pulse_a();
    rd(2'd0, v); chk("R5 rising count", v, 7);
    wr(2'd3, 16'h21);
    txa_in = 1'b1; idle(5);
    rd(2'd0, v); chk("R5 falling mode ignores rise", v, 7);
    txa_in = 1'b0; idle(5);
    rd(2'd0, v); chk("R5 falling mode counts fall", v, 6);
    wr(2'd3, 16'h20);
    pulse_a();
    rd(2'd0, v); chk("R4 event stopped holds", v, 6);
    wr(2'd0, 16'd1); wr(2'd3, 16'h11);
    pulse_a(); pulse_a();
    rd(2'd0, v); chk("R6 underflow reload A", v, 20);
    rd(2'd3, v); chk("R6 pend A on underflow", (v >> 1) & 1, 1);
    chk("R10 irq_a gated by enable", irq_a, 0);
    txb_in = 1'b1; idle(5);
    rd(2'd3, v); chk("R6 pend B on txb rise", (v >> 3) & 1, 1);
    chk("R10 irq_b", irq_b, 1);
    txb_in = 1'b0; idle(5);
    wr(2'd3, 16'h1B);
    rd(2'd3, v); chk("R11 write 1 keeps", v, 8'h1B);
    wr(2'd3, 16'h11);
    rd(2'd3, v); chk("R11 write 0 clears", v, 8'h11);
    wr(2'd3, 16'h1B);
    rd(2'd3, v); chk("R11 write 1 cannot set", v, 8'h11);

    // R8 capture edge selection table
    foreach (CAPT_VEC[i]) begin
      logic st;
      st = ~CAPT_VEC[i][2];
      txa_in = st; txb_in = st;
      wr(2'd0, 16'h8000);
      wr(2'd3, {8'h00, CAPT_VEC[i][5:3], 5'b0});
      idle(5);
      wr(2'd3, {8'h00, CAPT_VEC[i][5:3], 5'b0});
      txa_in = ~st; txb_in = ~st;
      idle(5);
      rd(2'd3, v);
      chk($sformatf("R8 pend A vec %0d", i), (v >> 1) & 1, CAPT_VEC[i][1]);
      chk($sformatf("R8 pend B vec %0d", i), (v >> 3) & 1, CAPT_VEC[i][0]);
    end

    // R9 capture value
    wr(2'd3, 16'h40); wr(2'd0, 16'd1000);
    txa_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v); chk("R9 captured value", v, 998);
    rd(2'd3, v); chk("R8 capture sets pend A", (v >> 1) & 1, 1);

    // R7 / R11 underflow in capture, set wins over clear
    wr(2'd0, 16'h8000); wr(2'd3, 16'h44); wr(2'd0, 16'd1);
    idle(1);
    wr(2'd3, 16'h44);
    rd(2'd3, v); chk("R11 set wins over clear", v, 8'h45);
    rd(2'd0, v); chk("R7 wrap to all ones", v, 16'hFFFF);
    chk("R10 irq_a from underflow", irq_a, 1);
    wr(2'd3, 16'h44);
    rd(2'd3, v); chk("R7 underflow flag cleared", v & 1, 0);
    chk("R10 irq_a low after clear", irq_a, 0);

    finish_run();
  end
endmodule